// File: doc/BRIEF.md
# Gated Programmable Clock Divider

The block derives a slower clock from its input clock. Software picks the divide ratio by writing a small code into a divisor register, and opens or closes an output gate through a separate enable register. The output is a single registered signal that is high for the first half of each divided period (rounded down) and low for the rest. It is meant for a leaf of a clock tree that needs a trimmable rate and a clean on/off control.

A divisor write is not applied at once. The code waits as a pending value, and a busy flag in the status register is raised. The code is installed only when the running output period ends, so every period on the output is a whole period of either the old ratio or the new one. While busy is set, further divisor writes are dropped. Codes that do not fit the divisor field are also dropped and leave everything as it was. A build parameter widens the field from five to six bits. In the wide build, bit 5 selects a fixed divide-by-64 stage that scales the lower five bits. In both builds a zero code selects the largest ratio.

The gate changes state only on cycles where the divided clock is low. This means opening or closing it never cuts a high pulse short.

Top module: `gated_clk_divider`

## Requirements
- R1: After reset the output is low and stays low, and the registers read as zero: gate register (address 0), divisor code (address 1) and status (address 2). The active code is 0.
- R2: Code 0 divides by the field mask plus one: 32 in the narrow build and 64 in the wide build (`WIDE`=1).
- R3: A code N from 1 to 31, written in either build with bit 5 clear, gives an output period of N input cycles. The output is high for floor(N/2) cycles and then low for the rest. Code 1 gives the same waveform as code 2 (1 high, 1 low).
- R4: In the wide build, a code with bit 5 set divides by 64 times bits 4:0. A code with bits 4:0 all zero then divides by 64.
- R5: A divisor write whose 8-bit value is above the mask (31 narrow, 63 wide) is rejected. Busy does not rise, and the code read back at address 1 is unchanged.
- R6: An accepted divisor write makes the status read return 0x18 (bits 4 and 3 set) in the next cycle. Status returns to 0 on the edge where the new code becomes active, and address 1 then reads the new code.
- R7: A divisor write made while busy is set is ignored. This includes a write that arrives on the very edge where the pending code is installed.
- R8: A new code takes effect only at the end of the output period that is running when it is written. That period completes with the old high and low lengths.
- R9: Bit 0 of address 0 is the enable request: 1 opens the gate and 0 closes it. Reading address 0 returns the request in bit 0 and the actual gate state in bit 1. With the gate closed, the output stays low.
- R10: The gate opens or closes only while the divided clock is low. As a result, every high pulse on the output has the full length for its period, whenever the enable is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register select: 0 gate, 1 divisor, 2 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| div_clk_o | output | 1 | Gated, divided clock output |

## Verification
Installing a pending code and accepting a new divisor write can fall on the same clock edge. The second write is then judged against a busy flag that is about to drop. The bench provokes this by writing a code during a high phase, then counting the low phase from its first low sample, and issuing a second write timed to land exactly on the period-ending edge. It judges the result from the ports: the status read in the following cycle must be zero, and the code read back must be the first code. The next waveform must have the first code's lengths. A write issued one cycle later, after the installation, must be accepted.

// File: rtl/gcdiv_pkg.sv
package gcdiv_pkg;

  // Widest divide ratio is 64 * 31 = 1984, which needs 11 bits.
  localparam int unsigned CNT_W    = 11;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BUSY_LSB = 3;
  localparam int unsigned BUSY_MSB = 4;

  typedef logic [CNT_W-1:0] span_t;

  typedef enum logic [1:0] {
    A_GATE = 2'd0,
    A_DIV  = 2'd1,
    A_STAT = 2'd2,
    A_RSVD = 2'd3
  } reg_sel_e;

  // Turns a divisor code into a period length in input cycles.
  function automatic span_t code_to_span(input logic [5:0] code, input bit wide);
    span_t n;
    if (wide && code[5]) n = {code[4:0], 6'b000000};
    else                 n = {6'b000000, code[4:0]};
    if (n == '0)                n = wide ? span_t'(64) : span_t'(32);
    else if (n == span_t'(1))   n = span_t'(2);
    return n;
  endfunction

  // Number of high cycles at the start of a period.
  function automatic span_t high_span(input span_t n);
    return n >> 1;
  endfunction

endpackage

// File: rtl/gcdiv_regs.sv
module gcdiv_regs
  import gcdiv_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic                 apply_i,
  input  logic [(WIDE ? 6 : 5)-1:0] act_code_i,
  input  logic                 gate_i,
  output logic                 en_o,
  output logic                 busy_o,
  output logic [(WIDE ? 6 : 5)-1:0] pend_code_o
);

  localparam int unsigned DIV_W = WIDE ? 6 : 5;
  localparam logic [REG_W-1:0] MASK = REG_W'((1 << DIV_W) - 1);

  logic             en_q;
  logic             busy_q;
  logic [DIV_W-1:0] pend_q;
  logic             hit_div;
  logic             hit_gate;
  logic             accept;

  assign hit_div  = wr_i && (addr_i == A_DIV);
  assign hit_gate = wr_i && (addr_i == A_GATE);
  assign accept   = hit_div && !busy_q && (wdata_i <= MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      if (hit_gate) en_q <= wdata_i[0];
      if (accept) begin
        busy_q <= 1'b1;
        pend_q <= wdata_i[DIV_W-1:0];
      end else if (apply_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_GATE: rdata_o = {{(REG_W-2){1'b0}}, gate_i, en_q};
      A_DIV:  rdata_o = REG_W'(act_code_i);
      A_STAT: rdata_o[BUSY_MSB:BUSY_LSB] = {2{busy_q}};
      default: rdata_o = '0;
    endcase
  end

  assign en_o        = en_q;
  assign busy_o      = busy_q;
  assign pend_code_o = pend_q;

endmodule

// File: rtl/gcdiv_core.sv
module gcdiv_core
  import gcdiv_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_valid_i,
  input  logic [(WIDE ? 6 : 5)-1:0] pend_code_i,
  output logic [(WIDE ? 6 : 5)-1:0] act_code_o,
  output logic                 div_o,
  output logic                 div_nxt_o,
  output logic                 period_end_o,
  output logic                 apply_o
);

  localparam int unsigned DIV_W = WIDE ? 6 : 5;
  localparam span_t RST_SPAN = code_to_span(6'd0, WIDE);

  span_t            n_q;
  span_t            cnt_q;
  logic             div_q;
  logic [DIV_W-1:0] code_q;
  logic [5:0]       pend6;

  span_t            n_nxt;
  span_t            cnt_nxt;
  logic             div_nxt;
  logic             period_end;
  logic             apply;

  // Code width seen by the decoder: the narrow build has no prescale bit.
  if (WIDE) begin : g_wide
    assign pend6 = pend_code_i;
  end else begin : g_narrow
    assign pend6 = {1'b0, pend_code_i};
  end

  assign period_end = (cnt_q == (n_q - span_t'(1)));
  assign apply      = period_end && pend_valid_i;
  assign n_nxt      = apply ? code_to_span(pend6, WIDE) : n_q;
  assign cnt_nxt    = period_end ? '0 : (cnt_q + span_t'(1));
  assign div_nxt    = period_end ? 1'b1 : ((cnt_q + span_t'(1)) < high_span(n_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= RST_SPAN;
      cnt_q  <= RST_SPAN - span_t'(1);
      div_q  <= 1'b0;
      code_q <= '0;
    end else begin
      n_q   <= n_nxt;
      cnt_q <= cnt_nxt;
      div_q <= div_nxt;
      if (apply) code_q <= pend_code_i;
    end
  end

  assign act_code_o   = code_q;
  assign div_o        = div_q;
  assign div_nxt_o    = div_nxt;
  assign period_end_o = period_end;
  assign apply_o      = apply;

endmodule

// File: rtl/gcdiv_gate.sv
module gcdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_nxt_i,
  output logic gate_o,
  output logic out_o
);

  logic gate_q;
  logic out_q;
  logic gate_nxt;

  // The gate follows the request only on edges after which the divided clock is low.
  assign gate_nxt = div_nxt_i ? gate_q : en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_nxt;
      out_q  <= gate_nxt & div_nxt_i;
    end
  end

  assign gate_o = gate_q;
  assign out_o  = out_q;

endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider
  import gcdiv_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       div_clk_o
);

  localparam int unsigned DIV_W = WIDE ? 6 : 5;

  logic             apply_evt;
  logic             period_end;
  logic             busy;
  logic             en_req;
  logic             gate_open;
  logic             div_q;
  logic             div_nxt;
  logic [DIV_W-1:0] pend_code;
  logic [DIV_W-1:0] act_code;

  gcdiv_regs #(.WIDE(WIDE)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .apply_i     (apply_evt),
    .act_code_i  (act_code),
    .gate_i      (gate_open),
    .en_o        (en_req),
    .busy_o      (busy),
    .pend_code_o (pend_code)
  );

  gcdiv_core #(.WIDE(WIDE)) core_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_valid_i (busy),
    .pend_code_i  (pend_code),
    .act_code_o   (act_code),
    .div_o        (div_q),
    .div_nxt_o    (div_nxt),
    .period_end_o (period_end),
    .apply_o      (apply_evt)
  );

  gcdiv_gate gate_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_req),
    .div_nxt_i (div_nxt),
    .gate_o    (gate_open),
    .out_o     (div_clk_o)
  );

endmodule

// File: rtl/gated_clk_divider_chk.sv
module gated_clk_divider_chk
  import gcdiv_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic [1:0]           addr_i,
  input logic [7:0]           wdata_i,
  input logic                 busy_i,
  input logic [(WIDE ? 6 : 5)-1:0] pend_code_i,
  input logic [(WIDE ? 6 : 5)-1:0] act_code_i,
  input logic                 div_i,
  input logic                 gate_i,
  input logic                 out_i,
  input logic                 period_end_i
);

  localparam int unsigned DIV_W = WIDE ? 6 : 5;
  localparam logic [7:0] MASK = 8'((1 << DIV_W) - 1);

  // R10: the output is never high unless the divided clock is high
  a_r10_out_needs_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_i |-> div_i);

  // R10: the gate moves only on edges that leave the divided clock low
  a_r10_gate_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_i) |-> !div_i);

  // R6: busy only rises after a divisor write
  a_r6_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wr_i && (addr_i == A_DIV)));

  // R6: when busy drops, the pending code is the active one
  a_r6_busy_drop_installs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (act_code_i == $past(pend_code_i)));

  // R8: the active code changes only at a period end with a code pending
  a_r8_code_at_period_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_code_i) |-> $past(period_end_i && busy_i));

  // R7: the pending code holds while busy
  a_r7_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(pend_code_i));

  // R5: an out-of-range write never raises busy
  a_r5_reject_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == A_DIV) && (wdata_i > MASK)) |=> !$rose(busy_i));

  // R3: the last cycle of each period is low
  a_r3_period_ends_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |-> !div_i);

endmodule

bind gated_clk_divider gated_clk_divider_chk #(.WIDE(WIDE)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (reg_wr_i),
  .addr_i       (reg_addr_i),
  .wdata_i      (reg_wdata_i),
  .busy_i       (busy),
  .pend_code_i  (pend_code),
  .act_code_i   (act_code),
  .div_i        (div_q),
  .gate_i       (gate_open),
  .out_i        (div_clk_o),
  .period_end_i (period_end)
);

// File: tb/gated_clk_divider_tb_top.sv
module gated_clk_divider_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NV = 13;
  // sel (0 narrow, 1 wide), code, expected high, expected low
  localparam int VEC [NV][4] = '{
    '{0,  1,  1,  1},   // R3 code 1 acts as 2
    '{0,  2,  1,  1},   // R3
    '{0,  3,  1,  2},   // R3 odd ratio
    '{0,  7,  3,  4},   // R3
    '{0, 31, 15, 16},   // R3 top code
    '{0, 16,  8,  8},   // R3
    '{0,  0, 16, 16},   // R2 narrow zero
    '{1,  5,  2,  3},   // R3 wide build, bit 5 clear
    '{1,  0, 32, 32},   // R2 wide zero
    '{1, 34, 64, 64},   // R4 0x22 -> 128
    '{1, 33, 32, 32},   // R4 0x21 -> 64
    '{1, 32, 32, 32},   // R4 0x20 -> 64
    '{1, 31, 15, 16}    // R3 wide
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b0;
  logic       wr_w = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata_n;
  logic [7:0] rdata_w;
  logic       out_n;
  logic       out_w;

  int n_chk = 0;
  int n_bad = 0;

  int   run [2];
  int   last_hi [2];
  int   last_lo [2];
  int   hi_ev [2];
  int   lo_ev [2];
  logic prev [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_clk_divider #(.WIDE(1'b0)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .reg_wr_i (wr_n), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata_n), .div_clk_o (out_n)
  );

  gated_clk_divider #(.WIDE(1'b1)) dut_w_i (
    .clk_i (clk), .rst_ni (rst_n), .reg_wr_i (wr_w), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata_w), .div_clk_o (out_w)
  );

  // Run-length monitor of both outputs, sampled at falling edges.
  initial begin
    for (int s = 0; s < 2; s++) begin
      run[s] = 0; last_hi[s] = 0; last_lo[s] = 0;
      hi_ev[s] = 0; lo_ev[s] = 0; prev[s] = 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int s = 0; s < 2; s++) begin
      logic cur;
      cur = (s == 1) ? out_w : out_n;
      if (rst_n) begin
        if (cur != prev[s]) begin
          if (prev[s]) begin last_hi[s] = run[s]; hi_ev[s]++; end
          else         begin last_lo[s] = run[s]; lo_ev[s]++; end
          run[s] = 1;
        end else begin
          run[s]++;
        end
      end
      prev[s] = cur;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Caller sits just after a falling edge; returns there one cycle later.
  task automatic wr_reg(input int sel, input logic [1:0] a, input logic [7:0] d,
                        input logic [1:0] ra, output logic [7:0] rd);
    addr = a; wdata = d;
    if (sel == 1) wr_w = 1'b1; else wr_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0; wr_w = 1'b0; addr = ra;
    #1;
    rd = (sel == 1) ? rdata_w : rdata_n;
  endtask

  task automatic rd_reg(input int sel, input logic [1:0] a, output logic [7:0] rd);
    @(negedge clk);
    addr = a;
    #1;
    rd = (sel == 1) ? rdata_w : rdata_n;
  endtask

  task automatic wait_idle(input int sel);
    logic [7:0] st;
    for (int i = 0; i < 5000; i++) begin
      rd_reg(sel, 2'd2, st);
      if (st == 8'h00) break;
    end
  endtask

  task automatic next_hi(input int sel, output int v);
    int k;
    k = hi_ev[sel];
    while (hi_ev[sel] == k) begin @(negedge clk); #1; end
    v = last_hi[sel];
  endtask

  task automatic next_lo(input int sel, output int v);
    int k;
    k = lo_ev[sel];
    while (lo_ev[sel] == k) begin @(negedge clk); #1; end
    v = last_lo[sel];
  endtask

  task automatic count_high(input int sel, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (((sel == 1) ? out_w : out_n) == 1'b1) n++;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    count_high(0, 40, v);             chk("R1 narrow output idle", v, 0);
    count_high(1, 10, v);             chk("R1 wide output idle", v, 0);
    rd_reg(0, 2'd0, st);              chk("R1 gate reg", st, 0);
    rd_reg(0, 2'd1, st);              chk("R1 divisor code", st, 0);
    rd_reg(0, 2'd2, st);              chk("R1 status", st, 0);
    rd_reg(1, 2'd1, st);              chk("R1 wide divisor code", st, 0);

    // R9 enable both, R2 default ratio, R10 first pulse complete
    wr_reg(0, 2'd0, 8'h01, 2'd0, st); chk("R9 enable request bit", int'(st[0]), 1);
    wr_reg(1, 2'd0, 8'h01, 2'd0, st);
    next_hi(0, v);                    chk("R2 narrow reset ratio high", v, 16);
    next_lo(0, v);                    chk("R2 narrow reset ratio low", v, 16);
    next_hi(1, v);                    chk("R2 wide reset ratio high", v, 32);

    // Vector table: R2, R3, R4 ratios and R6 handshake
    for (int i = 0; i < NV; i++) begin
      int    sel;
      string tag;
      sel = VEC[i][0];
      tag = (sel == 1 && VEC[i][1] >= 32) ? "R4" : (VEC[i][1] == 0) ? "R2" : "R3";
      @(negedge clk); #1;
      wr_reg(sel, 2'd1, 8'(VEC[i][1]), 2'd2, st);
      chk($sformatf("R6 busy after write, vector %0d", i), st, 8'h18);
      wait_idle(sel);
      rd_reg(sel, 2'd1, st);
      chk($sformatf("R6 code readback, vector %0d", i), st, VEC[i][1]);
      next_hi(sel, v); chk($sformatf("%s high, vector %0d", tag, i), v, VEC[i][2]);
      next_lo(sel, v); chk($sformatf("%s low, vector %0d", tag, i), v, VEC[i][3]);
    end

    // R5 out-of-range writes
    wr_reg(0, 2'd1, 8'd32, 2'd2, st);  chk("R5 narrow 32 no busy", st, 0);
    rd_reg(0, 2'd1, st);               chk("R5 narrow code kept", st, 0);
    wr_reg(0, 2'd1, 8'hFF, 2'd2, st);  chk("R5 narrow 0xFF no busy", st, 0);
    wr_reg(1, 2'd1, 8'h40, 2'd2, st);  chk("R5 wide 0x40 no busy", st, 0);
    rd_reg(1, 2'd1, st);               chk("R5 wide code kept", st, 31);
    next_hi(0, v);                     chk("R5 narrow ratio unchanged", v, 16);

    // R7 write while busy ignored
    wr_reg(0, 2'd1, 8'd8, 2'd2, st);   chk("R7 first write accepted", st, 8'h18);
    wr_reg(0, 2'd1, 8'd4, 2'd2, st);   chk("R7 still busy", st, 8'h18);
    wait_idle(0);
    rd_reg(0, 2'd1, st);               chk("R7 first code kept", st, 8);
    next_hi(0, v);                     chk("R7 ratio of first code high", v, 4);
    next_lo(0, v);                     chk("R7 ratio of first code low", v, 4);

    // Collision: write on the installing edge (R7, R8)
    next_lo(0, v);                     // now in the first high cycle
    wr_reg(0, 2'd1, 8'd16, 2'd2, st);  chk("R6 accepted in high phase", st, 8'h18);
    next_hi(0, v);                     chk("R8 old high kept", v, 4);
    repeat (3) begin @(negedge clk); #1; end
    wr_reg(0, 2'd1, 8'd3, 2'd2, st);   chk("R7 write on install edge dropped", st, 0);
    chk("R8 old low kept", last_lo[0], 4);
    rd_reg(0, 2'd1, st);               chk("R7 installed code", st, 16);
    next_hi(0, v);                     chk("R8 new high", v, 8);
    next_lo(0, v);                     chk("R8 new low", v, 8);
    wr_reg(0, 2'd1, 8'd2, 2'd2, st);   chk("R6 write after install accepted", st, 8'h18);
    wait_idle(0);
    next_hi(0, v);                     chk("R3 code 2 high", v, 1);

    // R8 long period interrupted by a short code
    wr_reg(0, 2'd1, 8'd0, 2'd2, st);
    wait_idle(0);
    next_lo(0, v);
    wr_reg(0, 2'd1, 8'd4, 2'd2, st);
    next_hi(0, v);                     chk("R8 running high finishes old", v, 16);
    next_lo(0, v);                     chk("R8 running low finishes old", v, 16);
    next_hi(0, v);                     chk("R8 then new high", v, 2);
    next_lo(0, v);                     chk("R8 then new low", v, 2);

    // R9, R10 disable during a high pulse
    wr_reg(0, 2'd1, 8'd0, 2'd2, st);
    wait_idle(0);
    next_lo(0, v);
    wr_reg(0, 2'd0, 8'h00, 2'd0, st);  chk("R9 request off, gate still open", st, 8'h02);
    next_hi(0, v);                     chk("R10 pulse completes after disable", v, 16);
    count_high(0, 80, v);              chk("R9 output stays low when closed", v, 0);
    rd_reg(0, 2'd0, st);               chk("R9 gate closed readback", st, 0);

    // R10 enable at every phase of a ratio-8 period
    wr_reg(0, 2'd1, 8'd8, 2'd2, st);
    wait_idle(0);
    for (int off = 0; off < 8; off++) begin
      repeat (off + 1) begin @(negedge clk); #1; end
      wr_reg(0, 2'd0, 8'h01, 2'd0, st);
      next_hi(0, v);                   chk($sformatf("R10 first pulse full, offset %0d", off), v, 4);
      rd_reg(0, 2'd0, st);             chk($sformatf("R9 gate open readback, offset %0d", off), st, 3);
      wr_reg(0, 2'd0, 8'h00, 2'd0, st);
      repeat (12) begin @(negedge clk); #1; end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule